// File: doc/BRIEF.md
# Escaped Command Frame Decoder

This block sits behind a host serial receiver and turns its byte stream into register writes. It waits for a fixed multi-byte opening sequence, then reads 16-bit command words, high byte first, until a closing byte arrives. It then goes back to waiting for the next opening sequence. Each command word holds a 4-bit register address and an 8-bit value. The value bits are spread across the word, and inverted copies of two of them are added. Because of this encoding, no legal payload byte can equal the closing byte, so the link needs no escape mechanism.

A word that passes every check leaves the block as a one-clock write strobe, with its address and data valid in the same cycle. Any other word is dropped and sets an error flag. The flag stays set until reset. A frame may hold any number of words, including none, and the writes leave the block in the order the words arrived.

Top module: `cmdframe_dec`

## Requirements
- R1: After reset, `wr_en` and `err` are 0 and the decoder is waiting for an opening sequence.
- R2: The opening sequence is the bytes 0x40, 0x4C, 0x44, 0x53, 0x7E, in that order. Any byte received before the full sequence has been seen produces no write.
- R3: A byte that breaks the opening sequence part-way sends the matcher back to its start. If that byte is 0x40, it counts as the first byte of a new sequence.
- R4: Each word arrives as two bytes, high byte first. The word's bits 11:8 give `wr_addr`. `wr_data` is bits 13:12 of the word followed by bits 5:0 of the word, so bits 13:12 become data bits 7:6 and bits 5:0 become data bits 5:0.
- R5: Each accepted word raises `wr_en` for exactly one clock, in the cycle after the edge that took in its low byte. The writes in a frame come out in arrival order.
- R6: A word is malformed if bit 6 is not the inverse of bit 5, or bit 14 is not the inverse of bit 13. A malformed word produces no write and sets `err`. The words that follow it in the same frame are still decoded.
- R7: A word with bit 7 or bit 15 set produces no write and sets `err`.
- R8: A 0x7E received at a word boundary ends the frame. The bytes that follow produce no write until a new opening sequence is seen.
- R9: A 0x7E received after only the high byte of a word drops that half word, sets `err` and ends the frame.
- R10: Once set, `err` stays at 1 until reset, whatever traffic follows.
- R11: A frame with no words (opening sequence followed at once by 0x7E) produces no write and leaves `err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address, valid while `wr_en` is high |
| wr_data | output | 8 | Register value, valid while `wr_en` is high |
| err | output | 1 | Sticky flag for malformed or truncated words |

## Verification
The bench builds the decoder with its default parameters: the five-byte opening sequence, 0x7E as the closing byte and the strict check on bits 7 and 15. At these widths the full set of 16 addresses times 256 values is small enough to send every word through real frames. The bench also sweeps every possible high byte against a fixed low byte, and every possible low byte against a fixed high byte. Together these two sweeps reach each padding-bit and inversion-bit failure separately. Directed frames cover restarts of the opening sequence, empty frames, a terminator after a half word, and the persistence of the error flag.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

   localparam int unsigned OCTET_W = 8;
   localparam int unsigned WORD_W  = 2 * OCTET_W;
   localparam int unsigned ADDR_W  = 4;
   localparam int unsigned DATA_W  = 8;

   typedef enum logic [0:0] {
      PH_HUNT = 1'b0,
      PH_BODY = 1'b1
   } phase_t;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } wr_cmd_t;

endpackage

// File: rtl/cfd_hdr_match.sv
module cfd_hdr_match
   import cfd_pkg::*;
#(
   parameter int unsigned             HDR_LEN = 5,
   parameter logic [8*HDR_LEN-1:0]    HDR_SEQ = 40'h40_4C_44_53_7E
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm,
   input  logic               byte_vld,
   input  logic [OCTET_W-1:0] byte_in,
   output logic               found
);

   localparam int unsigned IDX_W = (HDR_LEN > 1) ? $clog2(HDR_LEN) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_LEN - 1);
   localparam logic [OCTET_W-1:0] FIRST_BYTE = HDR_SEQ[8*HDR_LEN-1 -: 8];

   generate
      if (HDR_LEN < 2) begin : g_bad_len
         $error("cfd_hdr_match: HDR_LEN must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0]   idx_q;
   logic [OCTET_W-1:0] want;
   logic               hit;
   logic               step;

   always_comb begin
      want  = HDR_SEQ[8*(HDR_LEN-1-int'(idx_q)) +: 8];
      hit   = (byte_in == want);
      step  = arm && byte_vld;
      found = step && hit && (idx_q == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (step) begin
         if (hit && (idx_q != LAST_IDX))
            idx_q <= idx_q + IDX_W'(1);
         else if (hit)
            idx_q <= '0;
         else if (byte_in == FIRST_BYTE)
            idx_q <= IDX_W'(1);
         else
            idx_q <= '0;
      end
   end

   // R3: the matcher position never runs past the last sequence byte
   a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

   // R3: a mismatching first-sequence byte leaves the matcher at position one
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hit && byte_in == FIRST_BYTE) |=> (idx_q == IDX_W'(1)));

endmodule

// File: rtl/cfd_word_pack.sv
module cfd_word_pack
   import cfd_pkg::*;
#(
   parameter logic [OCTET_W-1:0] TERM_BYTE = 8'h7E
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               byte_vld,
   input  logic [OCTET_W-1:0] byte_in,
   output logic               word_vld,
   output logic [WORD_W-1:0]  word,
   output logic               frame_end,
   output logic               trunc
);

   logic               hi_have_q;
   logic [OCTET_W-1:0] hi_q;
   logic               fire;
   logic               is_term;

   always_comb begin
      fire      = en && byte_vld;
      is_term   = (byte_in == TERM_BYTE);
      frame_end = fire && is_term;
      trunc     = frame_end && hi_have_q;
      word_vld  = fire && !is_term && hi_have_q;
      word      = {hi_q, byte_in};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_have_q <= 1'b0;
         hi_q      <= '0;
      end else if (fire) begin
         if (is_term || hi_have_q) begin
            hi_have_q <= 1'b0;
         end else begin
            hi_have_q <= 1'b1;
            hi_q      <= byte_in;
         end
      end
   end

   // R4: a full word always leaves the packer with no high byte pending
   a_r4_pair_clears: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld |=> !hi_have_q);

endmodule

// File: rtl/cfd_word_chk.sv
module cfd_word_chk
   import cfd_pkg::*;
#(
   parameter bit STRICT_PAD = 1'b1
) (
   input  logic [WORD_W-1:0] word,
   output logic              ok,
   output wr_cmd_t           cmd
);

   logic pad_ok;
   logic inv_ok;

   generate
      if (STRICT_PAD) begin : g_pad_strict
         always_comb pad_ok = !word[15] && !word[7];
      end else begin : g_pad_loose
         always_comb pad_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      inv_ok   = (word[6] != word[5]) && (word[14] != word[13]);
      ok       = pad_ok && inv_ok;
      cmd.addr = word[11:8];
      cmd.data = {word[13:12], word[5:0]};
   end

endmodule

// File: rtl/cmdframe_dec.sv
module cmdframe_dec
   import cfd_pkg::*;
#(
   parameter int unsigned          HDR_LEN    = 5,
   parameter logic [8*HDR_LEN-1:0] HDR_SEQ    = 40'h40_4C_44_53_7E,
   parameter logic [7:0]           TERM_BYTE  = 8'h7E,
   parameter bit                   STRICT_PAD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       wr_en,
   output logic [3:0] wr_addr,
   output logic [7:0] wr_data,
   output logic       err
);

   generate
      if (OCTET_W != 8 || ADDR_W != 4 || DATA_W != 8) begin : g_bad_widths
         $error("cmdframe_dec: word encoding needs 8-bit bytes, 4-bit address, 8-bit data");
      end
   endgenerate

   phase_t            phase_q;
   logic              hdr_found;
   logic              word_vld;
   logic [WORD_W-1:0] word;
   logic              frame_end;
   logic              trunc;
   logic              word_ok;
   wr_cmd_t           cmd;
   logic              accept;
   logic              reject;

   cfd_hdr_match #(
      .HDR_LEN (HDR_LEN),
      .HDR_SEQ (HDR_SEQ)
   ) u_hdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (phase_q == PH_HUNT),
      .byte_vld (rx_valid),
      .byte_in  (rx_data),
      .found    (hdr_found)
   );

   cfd_word_pack #(
      .TERM_BYTE (TERM_BYTE)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (phase_q == PH_BODY),
      .byte_vld  (rx_valid),
      .byte_in   (rx_data),
      .word_vld  (word_vld),
      .word      (word),
      .frame_end (frame_end),
      .trunc     (trunc)
   );

   cfd_word_chk #(
      .STRICT_PAD (STRICT_PAD)
   ) u_chk (
      .word (word),
      .ok   (word_ok),
      .cmd  (cmd)
   );

   always_comb begin
      accept = word_vld && word_ok;
      reject = (word_vld && !word_ok) || trunc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_HUNT;
      end else if (phase_q == PH_HUNT) begin
         if (hdr_found) phase_q <= PH_BODY;
      end else if (frame_end) begin
         phase_q <= PH_HUNT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         err     <= 1'b0;
      end else begin
         wr_en <= accept;
         if (accept) begin
            wr_addr <= cmd.addr;
            wr_data <= cmd.data;
         end
         if (reject) err <= 1'b1;
      end
   end

   // R5: the write strobe never lasts two clocks
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R10: the error flag never drops without reset
   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R2: writes only come from bytes taken in while inside a frame
   a_r2_body_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(phase_q) == PH_BODY));

   // R6 / R7: a word that fails its checks writes nothing and flags an error
   a_r6_bad_word: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !word_ok) |=> (!wr_en && err));

   // R9: a half word cut by the terminator flags an error and closes the frame
   a_r9_trunc: assert property (@(posedge clk) disable iff (!rst_n)
      trunc |=> (err && !wr_en && phase_q == PH_HUNT));

   // R8: a terminator on a word boundary closes the frame
   a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !trunc) |=> (phase_q == PH_HUNT && !wr_en));

endmodule

// File: tb/cmdframe_dec_tb.sv
module cmdframe_dec_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       wr_en;
   logic [3:0] wr_addr;
   logic [7:0] wr_data;
   logic       err;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   cmdframe_dec u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_data  (rx_data),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .err      (err)
   );

   // R4 encoding: {0, ~v7, v7, v6, a[3:0], 0, ~v5, v5..v0}
   function automatic logic [15:0] enc(input logic [3:0] a, input logic [7:0] v);
      return {1'b0, ~v[7], v[7:6], a, 1'b0, ~v[5], v[5:0]};
   endfunction

   // R6 / R7 validity of any 16-bit word
   function automatic bit legal(input logic [15:0] w);
      return !w[15] && !w[7] && (w[14] != w[13]) && (w[6] != w[5]);
   endfunction

   task automatic fail_line(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
   endtask

   // Drive one byte, then sample one clock later, away from the edge.
   task automatic put(input logic [7:0] b, input bit ew, input logic [3:0] ea,
                      input logic [7:0] ed, input string tag);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      @(negedge clk);
      rx_valid = 1'b0;
      n_chk++;
      if (wr_en !== ew) fail_line(tag, "wr_en", 32'(wr_en), 32'(ew));
      else if (ew && (wr_addr !== ea || wr_data !== ed))
         fail_line(tag, "addr/data", {20'h0, wr_addr, wr_data}, {20'h0, ea, ed});
   endtask

   task automatic header(input string tag);
      put(8'h40, 0, 4'h0, 8'h00, tag);
      put(8'h4C, 0, 4'h0, 8'h00, tag);
      put(8'h44, 0, 4'h0, 8'h00, tag);
      put(8'h53, 0, 4'h0, 8'h00, tag);
      put(8'h7E, 0, 4'h0, 8'h00, tag);
   endtask

   task automatic word_raw(input logic [15:0] w, input bit ew, input string tag);
      put(w[15:8], 0, 4'h0, 8'h00, tag);
      put(w[7:0], ew, w[11:8], {w[13:12], w[5:0]}, tag);
   endtask

   task automatic chk_err(input bit e, input string tag);
      n_chk++;
      if (err !== e) fail_line(tag, "err", 32'(err), 32'(e));
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1: reset state
      n_chk++;
      if (wr_en !== 1'b0) fail_line("R1", "wr_en", 32'(wr_en), 0);
      chk_err(0, "R1");

      // R2: words before any opening sequence are ignored
      word_raw(enc(4'h3, 8'hA5), 0, "R2");
      word_raw(enc(4'h9, 8'h12), 0, "R2");
      put(8'h40, 0, 0, 0, "R2");
      put(8'h4C, 0, 0, 0, "R2");
      put(8'h7E, 0, 0, 0, "R2");
      word_raw(enc(4'h1, 8'h01), 0, "R2");

      // R3: broken sequence returns to start, 0x40 restarts at position one
      put(8'h40, 0, 0, 0, "R3"); put(8'h4C, 0, 0, 0, "R3");
      put(8'h44, 0, 0, 0, "R3"); put(8'h99, 0, 0, 0, "R3");
      put(8'h53, 0, 0, 0, "R3"); put(8'h7E, 0, 0, 0, "R3");
      word_raw(enc(4'h2, 8'h22), 0, "R3");
      put(8'h40, 0, 0, 0, "R3"); put(8'h4C, 0, 0, 0, "R3");
      put(8'h40, 0, 0, 0, "R3");
      put(8'h4C, 0, 0, 0, "R3"); put(8'h44, 0, 0, 0, "R3");
      put(8'h53, 0, 0, 0, "R3"); put(8'h7E, 0, 0, 0, "R3");
      word_raw(enc(4'h6, 8'hC3), 1, "R3");
      put(8'h7E, 0, 0, 0, "R3");
      put(8'h40, 0, 0, 0, "R3"); put(8'h4C, 0, 0, 0, "R3");
      put(8'h44, 0, 0, 0, "R3"); put(8'h53, 0, 0, 0, "R3");
      put(8'h40, 0, 0, 0, "R3");
      put(8'h4C, 0, 0, 0, "R3"); put(8'h44, 0, 0, 0, "R3");
      put(8'h53, 0, 0, 0, "R3"); put(8'h7E, 0, 0, 0, "R3");
      word_raw(enc(4'hF, 8'h7E), 1, "R3");
      put(8'h7E, 0, 0, 0, "R3");

      // R4 / R5: every address and value, 16 words per frame, in order
      for (int v = 0; v < 256; v++) begin
         header("R5");
         for (int a = 0; a < 16; a++)
            word_raw(enc(4'(a), 8'(v)), 1, "R4");
         put(8'h7E, 0, 0, 0, "R5");
      end
      chk_err(0, "R4");

      // R11: empty frame; R8: bytes after the terminator are ignored
      header("R11");
      put(8'h7E, 0, 0, 0, "R11");
      chk_err(0, "R11");
      word_raw(enc(4'h4, 8'h44), 0, "R8");
      header("R8");
      word_raw(enc(4'h5, 8'h55), 1, "R8");
      put(8'h7E, 0, 0, 0, "R8");
      word_raw(enc(4'h7, 8'h77), 0, "R8");
      chk_err(0, "R8");

      // R6: inversion failure drops the word, later words still decode
      header("R6");
      word_raw(enc(4'h1, 8'h10) ^ 16'h0040, 0, "R6");
      chk_err(1, "R6");
      word_raw(enc(4'h2, 8'h20), 1, "R6");
      put(8'h7E, 0, 0, 0, "R6");
      // R10: error persists across clean traffic
      header("R10");
      word_raw(enc(4'hA, 8'hAA), 1, "R10");
      put(8'h7E, 0, 0, 0, "R10");
      repeat (20) @(negedge clk);
      chk_err(1, "R10");
      do_reset();
      chk_err(0, "R1");

      // R7: padding bit set
      header("R7");
      word_raw(enc(4'h3, 8'h33) | 16'h8000, 0, "R7");
      chk_err(1, "R7");
      do_reset();
      header("R7");
      word_raw(enc(4'h3, 8'h33) | 16'h0080, 0, "R7");
      chk_err(1, "R7");
      do_reset();

      // R9: terminator after a high byte
      header("R9");
      put(enc(4'h8, 8'h81)[15:8], 0, 0, 0, "R9");
      put(8'h7E, 0, 0, 0, "R9");
      chk_err(1, "R9");
      word_raw(enc(4'h8, 8'h81), 0, "R9");
      do_reset();

      // R6 / R7 sweeps over every high byte and every low byte
      header("R7");
      for (int h = 0; h < 256; h++) begin
         if (h != 8'h7E) word_raw({8'(h), 8'h40}, legal({8'(h), 8'h40}), "R7");
      end
      for (int l = 0; l < 256; l++) begin
         if (l != 8'h7E) word_raw({8'h45, 8'(l)}, legal({8'h45, 8'(l)}), "R6");
      end
      put(8'h7E, 0, 0, 0, "R6");
      chk_err(1, "R6");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule